// File: doc/BRIEF.md
# Multi-Channel Edge Timestamp Capture

This block watches a bank of digital inputs on a 40 MHz sample clock, so one clock tick is 25 ns. Each channel passes through a two-stage synchroniser and then through an edge detector of its own. Software sets each detector to catch rising edges, falling edges, both, or none. A free-running counter of TS_W bits (31 by default) supplies the time base. Every qualifying edge becomes an event that holds the counter value at which the edge was seen and the direction of the edge.

Edges from different channels can occur in the same tick. Each channel therefore parks its event in a one-entry holding register. A fixed-priority arbiter moves one held event per clock into a shared FIFO, lowest channel number first, and tags it with the channel index. The FIFO is read from the other side with a show-ahead pop. It raises a full flag and a sticky overflow flag, and a downstream interrupt controller can use either one.

Top module: `edge_stamp_capture`

## Requirements
- R1: While rst_ni is low, and directly after it is released, empty_o is 1, full_o is 0, overflow_o is 0 and ts_now_o is 0.
- R2: ts_now_o rises by one on every clock and wraps to 0 after reaching 2^TS_W-1.
- R3: Channel c takes its detection mode from edge_mode_i[2c+1:2c]. The code 00 disables the channel, 01 catches rising edges only, 10 catches falling edges only and 11 catches both. An edge that the mode does not select produces no event.
- R4: An event word on rd_data_o is {channel[3:0], polarity, timestamp[TS_W-1:0]}, with channel in the top bits and polarity 1 for a rising edge and 0 for a falling edge.
- R5: Let T be the value of ts_now_o in the cycle in which an input level is applied. The event's timestamp is T+2, and the event is at the FIFO head with empty_o low by the fourth clock edge after the change.
- R6: Events that arrive on several channels in the same tick carry the same timestamp. They enter the FIFO one per clock in ascending channel order, with channel 0 first.
- R7: A channel that toggles on every sample produces one event per sample, with consecutive timestamps and alternating polarity.
- R8: full_o is 1 exactly when the FIFO holds FIFO_DEPTH events, and empty_o is 1 exactly when it holds none. The two are never 1 together.
- R9: An event that arrives while the FIFO is full and not being read is dropped, and overflow_o is set. overflow_o stays 1 until reset.
- R10: rd_en_i removes the head event when the FIFO is not empty. A read while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock (40 MHz nominal) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | NUM_CH | Asynchronous digital inputs |
| edge_mode_i | input | 2*NUM_CH | Per-channel detection mode, 2 bits per channel |
| rd_en_i | input | 1 | Pop the head event |
| rd_data_o | output | CH_W+1+TS_W | Head event {channel, polarity, timestamp} |
| empty_o | output | 1 | FIFO holds no events |
| full_o | output | 1 | FIFO holds FIFO_DEPTH events |
| overflow_o | output | 1 | Sticky: an event was dropped on a full FIFO |
| ts_now_o | output | TS_W | Free-running timestamp counter |

## Verification
The bench drives single-channel transitions from a vector table that covers every mode against both edge directions and both starting levels. This shows that selected edges produce events while deselected and disabled edges produce nothing, and it checks that the polarity bit and the channel tag land in the right fields. A burst of simultaneous edges on scattered channels tells fixed-priority ordering apart from arrival order or any other order. A channel toggled on every sample separates correct back-to-back capture from captures that are lost or merged. A fill past the FIFO depth separates dropping the newest event with a sticky flag from overwriting old entries. A small-counter instance shows the timestamp wrap.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RISE = 2'b01,
    MODE_FALL = 2'b10,
    MODE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/ecap_sync2.sv
module ecap_sync2 #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ecap_ts_cnt.sv
module ecap_ts_cnt #(
  parameter int TS_W = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_o <= '0;
    else         ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/ecap_edge_det.sv
module ecap_edge_det
  import ecap_pkg::*;
#(
  parameter int TS_W = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            s_i,
  input  logic [1:0]      mode_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic            drain_i,
  output logic            vld_o,
  output logic            pol_o,
  output logic [TS_W-1:0] ts_o
);
  edge_mode_e mode;
  logic prev_q, rise, fall, hit;

  assign mode = edge_mode_e'(mode_i);
  assign rise = s_i & ~prev_q;
  assign fall = ~s_i & prev_q;

  always_comb begin
    unique case (mode)
      MODE_RISE: hit = rise;
      MODE_FALL: hit = fall;
      MODE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= s_i;
  end

  // a new edge wins over a drain in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      pol_o <= 1'b0;
      ts_o  <= '0;
    end else if (hit) begin
      vld_o <= 1'b1;
      pol_o <= rise;
      ts_o  <= ts_i;
    end else if (drain_i) begin
      vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ecap_prio_arb.sv
module ecap_prio_arb #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/ecap_fifo.sv
module ecap_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          push_ok, pop_ok;

  assign empty_o = (count == '0);
  assign full_o  = (count == DEPTH[AW:0]);
  assign pop_ok  = pop_i & ~empty_o;
  assign push_ok = push_i & (~full_o | pop_ok);
  assign data_o  = mem_q[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_i && !push_ok) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture #(
  parameter int NUM_CH     = 16,
  parameter int TS_W       = 31,
  parameter int FIFO_DEPTH = 16,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int EV_W      = CH_W + 1 + TS_W
) (
  input  logic [0:0]          clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CH-1:0]   sig_i,
  input  logic [2*NUM_CH-1:0] edge_mode_i,
  input  logic                rd_en_i,
  output logic [EV_W-1:0]     rd_data_o,
  output logic                empty_o,
  output logic                full_o,
  output logic                overflow_o,
  output logic [TS_W-1:0]     ts_now_o
);
  logic [NUM_CH-1:0] sig_s, hold_vld, hold_pol, grant;
  logic [TS_W-1:0]   hold_ts [NUM_CH];
  logic [CH_W-1:0]   sel_idx;
  logic              sel_any;
  logic [EV_W-1:0]   ev_word;

  ecap_sync2 #(.W(NUM_CH)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sig_i), .q_o(sig_s)
  );

  ecap_ts_cnt #(.TS_W(TS_W)) u_ts (
    .clk_i(clk_i), .rst_ni(rst_ni), .ts_o(ts_now_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ecap_edge_det #(.TS_W(TS_W)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .s_i    (sig_s[c]),
      .mode_i (edge_mode_i[2*c +: 2]),
      .ts_i   (ts_now_o),
      .drain_i(grant[c]),
      .vld_o  (hold_vld[c]),
      .pol_o  (hold_pol[c]),
      .ts_o   (hold_ts[c])
    );
  end

  ecap_prio_arb #(.N(NUM_CH), .IW(CH_W)) u_arb (
    .req_i(hold_vld), .grant_o(grant), .idx_o(sel_idx), .any_o(sel_any)
  );

  assign ev_word = {sel_idx, hold_pol[sel_idx], hold_ts[sel_idx]};

  ecap_fifo #(.W(EV_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (sel_any),
    .data_i (ev_word),
    .pop_i  (rd_en_i),
    .data_o (rd_data_o),
    .empty_o(empty_o),
    .full_o (full_o),
    .ovf_o  (overflow_o)
  );
endmodule

// File: rtl/ecap_chk.sv
module ecap_chk #(
  parameter int NUM_CH = 16,
  parameter int TS_W   = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              empty_i,
  input logic              full_i,
  input logic              ovf_i,
  input logic [TS_W-1:0]   ts_i,
  input logic [NUM_CH-1:0] hold_vld_i,
  input logic [NUM_CH-1:0] grant_i
);
  logic            armed;
  logic [TS_W-1:0] prev_ts;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed   <= 1'b0;
      prev_ts <= '0;
    end else begin
      armed   <= 1'b1;
      prev_ts <= ts_i;
    end
  end

  // R2
  ts_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> ts_i == prev_ts + 1'b1);

  // R8
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_i && full_i));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(ovf_i)) |-> ovf_i);

  // R9
  ovf_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $rose(ovf_i)) |-> $past(full_i));

  // R6
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  // R6
  ch0_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_vld_i[0] |-> grant_i[0]);
endmodule

bind edge_stamp_capture ecap_chk #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .empty_i   (empty_o),
  .full_i    (full_o),
  .ovf_i     (overflow_o),
  .ts_i      (ts_now_o),
  .hold_vld_i(hold_vld),
  .grant_i   (grant)
);

// File: tb/edge_stamp_capture_tb.sv
`timescale 1ns/1ps
module edge_stamp_capture_tb;
  localparam int NCH = 16;
  localparam int TSW = 31;
  localparam int DEP = 16;
  localparam int EVW = 4 + 1 + TSW;

  typedef struct packed {
    logic [3:0] ch;
    logic [1:0] mode;
    logic       lvl0;
    logic       lvl1;
    logic       exp_ev;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  2'b01, 1'b0, 1'b1, 1'b1},
    '{4'd0,  2'b01, 1'b1, 1'b0, 1'b0},
    '{4'd2,  2'b10, 1'b1, 1'b0, 1'b1},
    '{4'd2,  2'b10, 1'b0, 1'b1, 1'b0},
    '{4'd9,  2'b11, 1'b0, 1'b1, 1'b1},
    '{4'd9,  2'b11, 1'b1, 1'b0, 1'b1},
    '{4'd11, 2'b00, 1'b0, 1'b1, 1'b0},
    '{4'd15, 2'b11, 1'b1, 1'b0, 1'b1},
    '{4'd6,  2'b01, 1'b0, 1'b1, 1'b1},
    '{4'd12, 2'b00, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCH-1:0]   sig = '0;
  logic [2*NCH-1:0] mode = '0;
  logic rd_en = 1'b0;
  logic [EVW-1:0] rd_data;
  logic empty, full, ovf;
  logic [TSW-1:0] ts_now;

  logic [8:0] w_data;
  logic w_empty, w_full, w_ovf;
  logic [3:0] w_ts;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_stamp_capture u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sig_i(sig), .edge_mode_i(mode),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .empty_o(empty), .full_o(full),
    .overflow_o(ovf), .ts_now_o(ts_now)
  );

  edge_stamp_capture #(.TS_W(4)) u_wrap (
    .clk_i(clk), .rst_ni(rst_ni), .sig_i('0), .edge_mode_i('0),
    .rd_en_i(1'b0), .rd_data_o(w_data), .empty_o(w_empty), .full_o(w_full),
    .overflow_o(w_ovf), .ts_now_o(w_ts)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop();
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    sig = '0;
    mode = '0;
    rd_en = 1'b0;
    tick(3);
    chk("R1 empty in reset", 64'(empty), 64'd1);
    chk("R1 full in reset", 64'(full), 64'd0);
    chk("R1 overflow in reset", 64'(ovf), 64'd0);
    chk("R1 ts in reset", 64'(ts_now), 64'd0);
    rst_ni = 1'b1;
    tick(3);
  endtask

  function automatic logic [EVW-1:0] ev(input int ch, input logic pol, input logic [TSW-1:0] ts);
    return {4'(ch), pol, ts};
  endfunction

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [TSW-1:0] t0;
    do_reset();

    // R1 directly after release
    chk("R1 empty after release", 64'(empty), 64'd1);
    chk("R1 overflow after release", 64'(ovf), 64'd0);

    // R2 step
    t0 = ts_now;
    tick(1);
    chk("R2 counter step", 64'(ts_now), 64'(TSW'(t0 + 1)));

    // R10 read on empty has no effect
    pop();
    chk("R10 empty read ignored", 64'(empty), 64'd1);
    chk("R10 full after empty read", 64'(full), 64'd0);

    // R3 R4 R5 vector walk
    for (int v = 0; v < NV; v++) begin
      mode = '0;
      sig[VECS[v].ch] = VECS[v].lvl0;
      tick(4);
      mode[2*VECS[v].ch +: 2] = VECS[v].mode;
      tick(1);
      t0 = ts_now;
      sig[VECS[v].ch] = VECS[v].lvl1;
      tick(4);
      if (VECS[v].exp_ev) begin
        chk("R5 event present", 64'(empty), 64'd0);
        chk("R4 R5 event word", 64'(rd_data),
            64'(ev(VECS[v].ch, VECS[v].lvl1, TSW'(t0 + 2))));
        pop();
      end else begin
        tick(2);
        chk("R3 deselected edge ignored", 64'(empty), 64'd1);
      end
      chk("R10 drained", 64'(empty), 64'd1);
    end

    // R6 simultaneous edges
    do_reset();
    mode[2*0 +: 2] = 2'b11;
    mode[2*3 +: 2] = 2'b11;
    mode[2*7 +: 2] = 2'b11;
    mode[2*15 +: 2] = 2'b11;
    tick(1);
    t0 = ts_now;
    sig[0] = 1'b1; sig[3] = 1'b1; sig[7] = 1'b1; sig[15] = 1'b1;
    tick(10);
    chk("R6 order ch0", 64'(rd_data), 64'(ev(0, 1'b1, TSW'(t0 + 2))));
    pop();
    chk("R6 order ch3", 64'(rd_data), 64'(ev(3, 1'b1, TSW'(t0 + 2))));
    pop();
    chk("R6 order ch7", 64'(rd_data), 64'(ev(7, 1'b1, TSW'(t0 + 2))));
    pop();
    chk("R6 order ch15", 64'(rd_data), 64'(ev(15, 1'b1, TSW'(t0 + 2))));
    pop();
    chk("R6 no extra", 64'(empty), 64'd1);

    // R7 toggle every sample
    do_reset();
    mode[2*5 +: 2] = 2'b11;
    tick(1);
    t0 = ts_now;
    sig[5] = 1'b1; tick(1);
    sig[5] = 1'b0; tick(1);
    sig[5] = 1'b1; tick(1);
    sig[5] = 1'b0; tick(6);
    for (int i = 0; i < 4; i++) begin
      chk("R7 back-to-back event", 64'(rd_data),
          64'(ev(5, (i % 2) == 0, TSW'(t0 + 2 + TSW'(i)))));
      pop();
    end
    chk("R7 exactly four", 64'(empty), 64'd1);

    // R8 R9 fill and overflow
    do_reset();
    mode[2*1 +: 2] = 2'b11;
    tick(1);
    for (int i = 0; i < DEP; i++) begin
      sig[1] = ~sig[1];
      tick(2);
    end
    tick(4);
    chk("R8 full at depth", 64'(full), 64'd1);
    chk("R9 no overflow at depth", 64'(ovf), 64'd0);
    sig[1] = ~sig[1];
    tick(6);
    chk("R9 overflow set", 64'(ovf), 64'd1);
    chk("R8 still full", 64'(full), 64'd1);
    for (int i = 0; i < DEP; i++) begin
      chk("R9 kept entry polarity", 64'(rd_data[TSW]), 64'((i % 2) == 0));
      pop();
    end
    chk("R9 extra event dropped", 64'(empty), 64'd1);
    chk("R9 overflow sticky", 64'(ovf), 64'd1);
    chk("R8 not full when empty", 64'(full), 64'd0);

    // R2 wrap on small counter
    for (int i = 0; i < 20 && w_ts != 4'hf; i++) tick(1);
    chk("R2 reaches max", 64'(w_ts), 64'hf);
    tick(1);
    chk("R2 wraps to zero", 64'(w_ts), 64'd0);

    do_reset();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule